// File: doc/BRIEF.md
# Strobed Host Port with Color Lookup Table

This block gives a microprocessor access to a small register set and a 256-entry color lookup table inside a video device. The host side is a strobe bus: each access is one low pulse of an active-low select. The direction bit and the 2-bit register address are taken when the select falls. Write data is taken when the select rises. Each lookup-table entry holds three 8-bit color components. The block has no host clock of its own. The select edges are brought into the system clock domain by a synchronizer and an edge detector, and every internal update is made on a detected edge.

The port works as a one-step pipeline. A write is held as pending and reaches its target register only at the next select falling edge. A lookup-table read sequence needs one priming step before it returns data. Each step in the sequence then returns one component, and every step leaves an advance pending. A read of the control register commits all pending work and changes nothing else, so it is a safe way to end a sequence. The pixel path has its own read-only port into the table, with one cycle of latency.

Top module: `clut_host_port`

## Requirements
- R1: Register addresses are 0 = table write index, 1 = table data, 2 = control, 3 = table read index. A read of address 0, 2 or 3 returns that register's committed value. After reset, all registers read 0x00.
- R2: A host write takes effect only at the next select falling edge. Until that edge, the old value stays visible, both through the pixel port and through register reads.
- R3: Writes to address 1 fill the components of entry [write index] in order: first, second, third. The three bytes are stored together as {first,second,third} = color[23:16], [15:8], [7:0]. The write index then increments and the component count restarts.
- R4: A write to address 0 sets the write index and restarts the write component count at the first component.
- R5: After a write to address 3, the first read of address 1 is a priming step and returns 0x00. Later reads of address 1 return the first, second and third components of entry [read index], then continue with the next entry.
- R6: A read of address 3 returns the read index as it is after all pending read advances have been committed. The index has moved past an entry once that entry's third component has been read and one more falling edge has followed.
- R7: During a read, dout_en is high from the detected falling edge until the detected rising edge. At all other times dout_en is low and dout is 0x00.
- R8: Pixel port: each cycle that pix_valid is high, pix_out_valid is high on the next cycle, with pix_color = table[pix_index] as it was at the request. There is no back-pressure, so the consumer must take every result.
- R9: The component counters never go beyond the third component.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Host select strobe, active low, asynchronous |
| rnw | input | 1 | 1 = read, 0 = write; taken at the select falling edge |
| addr | input | 2 | Register address; taken at the select falling edge |
| din | input | 8 | Host write data; taken at the select rising edge |
| dout | output | 8 | Host read data, 0 when not driving |
| dout_en | output | 1 | High while read data is driven |
| pix_valid | input | 1 | Pixel lookup request valid |
| pix_index | input | 8 | Pixel lookup index |
| pix_out_valid | output | 1 | Pixel result valid, one cycle after request |
| pix_color | output | 24 | Pixel color {first,second,third} |

## Verification
A wrong component counter shows up in the very next read sequence as bytes in the wrong order. It also shows up as a table entry made from bytes of neighbouring writes, which the pixel port shows one cycle after a lookup. A commit that comes a step too early or too late is visible through the pixel port between a write's rising edge and the next falling edge. A priming flag in the wrong state shifts every byte of a read sequence by one step, so the error appears at the first data read.

// File: rtl/clut_pkg.sv
package clut_pkg;
  localparam int DATA_W = 8;
  localparam int COMPS  = 3;
  localparam int COLOR_W = DATA_W * COMPS;
  localparam logic [1:0] A_WIDX = 2'd0;
  localparam logic [1:0] A_DATA = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;
  localparam logic [1:0] A_RIDX = 2'd3;
endpackage

// File: rtl/cs_edge_sync.sv
module cs_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  output logic fall,
  output logic rise
);
  logic [STAGES:0] sh;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-1:0], cs_n};
  end
  assign fall = sh[STAGES] & ~sh[STAGES-1];
  assign rise = ~sh[STAGES] & sh[STAGES-1];
endmodule

// File: rtl/clut_store.sv
module clut_store #(
  parameter int IDX_W = 8,
  parameter int COLOR_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [IDX_W-1:0]   waddr,
  input  logic [COLOR_W-1:0] wdata,
  input  logic [IDX_W-1:0]   haddr,
  output logic [COLOR_W-1:0] hdata,
  input  logic               pix_valid,
  input  logic [IDX_W-1:0]   pix_index,
  output logic               pix_out_valid,
  output logic [COLOR_W-1:0] pix_color
);
  localparam int DEPTH = 1 << IDX_W;
  logic [COLOR_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign hdata = mem[haddr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_out_valid <= 1'b0;
      pix_color     <= '0;
    end else begin
      pix_out_valid <= pix_valid;
      if (pix_valid) pix_color <= mem[pix_index];
    end
  end
endmodule

// File: rtl/host_seq.sv
module host_seq
  import clut_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_fall,
  input  logic               cs_rise,
  input  logic               rnw,
  input  logic [1:0]         addr,
  input  logic [DATA_W-1:0]  din,
  output logic [DATA_W-1:0]  dout,
  output logic               dout_en,
  output logic               st_we,
  output logic [IDX_W-1:0]   st_waddr,
  output logic [COLOR_W-1:0] st_wdata,
  output logic [IDX_W-1:0]   st_haddr,
  input  logic [COLOR_W-1:0] st_hdata
);
  logic [IDX_W-1:0]   widx, ridx;
  logic [1:0]         wcomp, rcomp;
  logic [DATA_W-1:0]  ctrl_q, pend_data;
  logic [DATA_W-1:0]  stage [COMPS-1];
  logic [COLOR_W-1:0] rbuf;
  logic               primed, pend_wr, pend_rd, op_rd;
  logic [1:0]         op_addr;
  logic               last_w, last_r;

  assign last_w   = (wcomp == 2'(COMPS-1));
  assign last_r   = (rcomp == 2'(COMPS-1));
  assign st_we    = cs_fall && pend_wr && (op_addr == A_DATA) && last_w;
  assign st_waddr = widx;
  assign st_wdata = {stage[0], stage[1], pend_data};
  assign st_haddr = (primed && last_r) ? ridx + 1'b1 : ridx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      widx <= '0; ridx <= '0; wcomp <= '0; rcomp <= '0;
      ctrl_q <= '0; pend_data <= '0; rbuf <= '0;
      primed <= 1'b0; pend_wr <= 1'b0; pend_rd <= 1'b0;
      op_rd <= 1'b0; op_addr <= '0; dout_en <= 1'b0;
      for (int i = 0; i < COMPS-1; i++) stage[i] <= '0;
    end else if (cs_fall) begin
      if (pend_wr) begin
        unique case (op_addr)
          A_WIDX: begin widx <= pend_data[IDX_W-1:0]; wcomp <= '0; end
          A_DATA: begin
            if (last_w) begin
              widx  <= widx + 1'b1;
              wcomp <= '0;
            end else begin
              stage[wcomp] <= pend_data;
              wcomp <= wcomp + 1'b1;
            end
          end
          A_CTRL: ctrl_q <= pend_data;
          A_RIDX: begin
            ridx <= pend_data[IDX_W-1:0]; rcomp <= '0; primed <= 1'b0;
          end
        endcase
      end else if (pend_rd) begin
        if (!primed) begin
          rbuf   <= st_hdata;
          primed <= 1'b1;
        end else if (last_r) begin
          rbuf  <= st_hdata;
          ridx  <= ridx + 1'b1;
          rcomp <= '0;
        end else begin
          rcomp <= rcomp + 1'b1;
        end
      end
      pend_wr <= 1'b0;
      pend_rd <= rnw && (addr == A_DATA);
      op_rd   <= rnw;
      op_addr <= addr;
      dout_en <= rnw;
    end else if (cs_rise) begin
      dout_en <= 1'b0;
      if (!op_rd) begin
        pend_wr   <= 1'b1;
        pend_data <= din;
      end
    end
  end

  always_comb begin
    dout = '0;
    if (dout_en) begin
      unique case (op_addr)
        A_WIDX: dout = DATA_W'(widx);
        A_DATA: dout = primed ? rbuf[COLOR_W-1-DATA_W*rcomp -: DATA_W] : '0;
        A_CTRL: dout = ctrl_q;
        A_RIDX: dout = DATA_W'(ridx);
      endcase
    end
  end
endmodule

// File: rtl/clut_host_port.sv
module clut_host_port
  import clut_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               rnw,
  input  logic [1:0]         addr,
  input  logic [DATA_W-1:0]  din,
  output logic [DATA_W-1:0]  dout,
  output logic               dout_en,
  input  logic               pix_valid,
  input  logic [IDX_W-1:0]   pix_index,
  output logic               pix_out_valid,
  output logic [COLOR_W-1:0] pix_color
);
  logic               cs_fall, cs_rise, st_we;
  logic [IDX_W-1:0]   st_waddr, st_haddr;
  logic [COLOR_W-1:0] st_wdata, st_hdata;

  cs_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .fall(cs_fall), .rise(cs_rise));

  host_seq #(.IDX_W(IDX_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .rnw(rnw), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .st_we(st_we), .st_waddr(st_waddr), .st_wdata(st_wdata),
    .st_haddr(st_haddr), .st_hdata(st_hdata));

  clut_store #(.IDX_W(IDX_W), .COLOR_W(COLOR_W)) store_i (
    .clk(clk), .rst_n(rst_n), .we(st_we), .waddr(st_waddr),
    .wdata(st_wdata), .haddr(st_haddr), .hdata(st_hdata),
    .pix_valid(pix_valid), .pix_index(pix_index),
    .pix_out_valid(pix_out_valid), .pix_color(pix_color));
endmodule

// File: rtl/clut_host_port_chk.sv
module clut_host_port_chk #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_fall,
  input logic             cs_rise,
  input logic             dout_en,
  input logic [7:0]       dout,
  input logic             pix_valid,
  input logic             pix_out_valid,
  input logic             st_we,
  input logic [IDX_W-1:0] widx,
  input logic [7:0]       ctrl_q,
  input logic [1:0]       wcomp,
  input logic [1:0]       rcomp
);
  AST_DRIVE_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(dout_en) |-> $past(cs_fall)); // R7
  AST_DRIVE_STOP: assert property (@(posedge clk) disable iff (!rst_n) cs_rise |=> !dout_en); // R7
  AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n) !dout_en |-> dout == 8'h00); // R7
  AST_COMMIT_EDGE: assert property (@(posedge clk) disable iff (!rst_n) !cs_fall |=> $stable(widx) && $stable(ctrl_q)); // R2
  AST_STORE_EDGE: assert property (@(posedge clk) disable iff (!rst_n) st_we |-> cs_fall); // R2
  AST_PIX_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) pix_valid |=> pix_out_valid); // R8
  AST_PIX_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n) !pix_valid |=> !pix_out_valid); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) wcomp <= 2'd2 && rcomp <= 2'd2); // R9
endmodule

bind clut_host_port clut_host_port_chk #(.IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
  .dout_en(dout_en), .dout(dout), .pix_valid(pix_valid),
  .pix_out_valid(pix_out_valid), .st_we(st_we), .widx(seq_i.widx),
  .ctrl_q(seq_i.ctrl_q), .wcomp(seq_i.wcomp), .rcomp(seq_i.rcomp));

// File: tb/clut_host_port_tb_top.sv
module clut_host_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rnw = 1'b1, pix_valid = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] din = '0, pix_index = '0, dout;
  logic dout_en, pix_out_valid;
  logic [23:0] pix_color;
  int checks = 0, errors = 0;
  logic [7:0] rd;
  logic done = 1'b0;

  always #10 clk = ~clk;

  clut_host_port dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rnw(rnw), .addr(addr),
    .din(din), .dout(dout), .dout_en(dout_en), .pix_valid(pix_valid),
    .pix_index(pix_index), .pix_out_valid(pix_out_valid),
    .pix_color(pix_color));

  // {rnw, addr, data, check, expected}
  localparam int NV = 17;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 2'd0, 8'h10, 1'b0, 8'h00},  // R4 write index 0x10
    {1'b0, 2'd1, 8'hAA, 1'b0, 8'h00},  // R3
    {1'b0, 2'd1, 8'hBB, 1'b0, 8'h00},
    {1'b0, 2'd1, 8'hCC, 1'b0, 8'h00},
    {1'b0, 2'd1, 8'h11, 1'b0, 8'h00},
    {1'b0, 2'd1, 8'h22, 1'b0, 8'h00},
    {1'b0, 2'd1, 8'h33, 1'b0, 8'h00},
    {1'b1, 2'd0, 8'h00, 1'b1, 8'h12},  // R3 index advanced twice
    {1'b0, 2'd3, 8'h10, 1'b0, 8'h00},
    {1'b1, 2'd1, 8'h00, 1'b1, 8'h00},  // R5 priming returns 0
    {1'b1, 2'd1, 8'h00, 1'b1, 8'hAA},  // R5
    {1'b1, 2'd1, 8'h00, 1'b1, 8'hBB},
    {1'b1, 2'd1, 8'h00, 1'b1, 8'hCC},
    {1'b1, 2'd1, 8'h00, 1'b1, 8'h11},  // R5 next entry
    {1'b1, 2'd3, 8'h00, 1'b1, 8'h11},  // R6
    {1'b0, 2'd2, 8'h5A, 1'b0, 8'h00},
    {1'b1, 2'd2, 8'h00, 1'b1, 8'h5A}   // R1
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic [1:0] a, input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    rnw = r; addr = a; din = d;
    repeat (2) @(negedge clk);
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
    q = dout;
    if (r) check("R7 drive", {31'd0, dout_en}, 32'd1);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic pix(input logic [7:0] idx, output logic [23:0] c);
    @(negedge clk);
    pix_valid = 1'b1; pix_index = idx;
    @(negedge clk);
    pix_valid = 1'b0;
    check("R8 valid", {31'd0, pix_out_valid}, 32'd1);
    c = pix_color;
    @(negedge clk);
    check("R8 drop", {31'd0, pix_out_valid}, 32'd0);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin @(posedge clk); cyc++; end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [23:0] c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 reset dout_en", {31'd0, dout_en}, 32'd0);
    check("R7 reset dout", {24'd0, dout}, 32'd0);
    check("R8 reset pix", {31'd0, pix_out_valid}, 32'd0);
    step(1'b1, 2'd2, 8'h00, rd); check("R1 reset ctrl", {24'd0, rd}, 32'h00);
    step(1'b1, 2'd0, 8'h00, rd); check("R1 reset widx", {24'd0, rd}, 32'h00);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][19], VEC[i][18:17], VEC[i][16:9], rd);
      if (VEC[i][8]) check($sformatf("R1/R3/R5/R6 vec %0d", i), {24'd0, rd}, {24'd0, VEC[i][7:0]});
    end
    check("R7 idle dout_en", {31'd0, dout_en}, 32'd0);

    // R3 packing through pixel port
    pix(8'h10, c); check("R3 entry 0x10", {8'd0, c}, 32'hAABBCC);
    pix(8'h11, c); check("R3 entry 0x11", {8'd0, c}, 32'h112233);

    // R2 late commit: seed entry 0x40, then overwrite and watch
    step(1'b0, 2'd0, 8'h40, rd);
    step(1'b0, 2'd1, 8'h07, rd);
    step(1'b0, 2'd1, 8'h08, rd);
    step(1'b0, 2'd1, 8'h09, rd);
    step(1'b1, 2'd2, 8'h00, rd);
    pix(8'h40, c); check("R2 seed", {8'd0, c}, 32'h070809);
    step(1'b0, 2'd0, 8'h40, rd);
    step(1'b0, 2'd1, 8'h01, rd);
    step(1'b0, 2'd1, 8'h02, rd);
    step(1'b0, 2'd1, 8'h03, rd);
    pix(8'h40, c); check("R2 not yet committed", {8'd0, c}, 32'h070809);
    step(1'b1, 2'd2, 8'h00, rd); check("R1 terminator ctrl", {24'd0, rd}, 32'h5A);
    pix(8'h40, c); check("R2 committed", {8'd0, c}, 32'h010203);
    step(1'b1, 2'd0, 8'h00, rd); check("R3 index after entry", {24'd0, rd}, 32'h41);

    // R4: restart component count mid-entry
    step(1'b0, 2'd0, 8'h50, rd);
    step(1'b0, 2'd1, 8'hEE, rd);
    step(1'b0, 2'd0, 8'h50, rd);
    step(1'b0, 2'd1, 8'h0A, rd);
    step(1'b0, 2'd1, 8'h0B, rd);
    step(1'b0, 2'd1, 8'h0C, rd);
    step(1'b1, 2'd2, 8'h00, rd);
    pix(8'h50, c); check("R4 restart", {8'd0, c}, 32'h0A0B0C);

    // R2 control write not visible before next fall, visible after
    step(1'b0, 2'd2, 8'hC3, rd);
    step(1'b1, 2'd2, 8'h00, rd); check("R2 ctrl commit", {24'd0, rd}, 32'hC3);

    // R5: new read index requires priming again
    step(1'b0, 2'd3, 8'h50, rd);
    step(1'b1, 2'd1, 8'h00, rd); check("R5 reprime", {24'd0, rd}, 32'h00);
    step(1'b1, 2'd1, 8'h00, rd); check("R5 first", {24'd0, rd}, 32'h0A);
    step(1'b1, 2'd3, 8'h00, rd); check("R6 index held", {24'd0, rd}, 32'h50);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule